// File: doc/BRIEF.md
# Burst Column Sequencer with Read Byte-Enable Delay

This block sits beside the page buffer of a synchronous graphics memory and generates, beat by beat, the column addresses of a read or write burst inside one open page of 256 columns. It follows the programmed burst length and ordering. A fixed-length burst can be cut short by a burst-stop, by a same-bank precharge or by a fresh read or write, unless it was opened with auto precharge. In that case it runs to its end and then raises a one-cycle request for the precharge logic.

Write beats leave the block one cycle after the write is presented. Read beats are held back so that they line up with the read data, which appears CAS-latency cycles after the read. The read byte masks are delayed by a fixed two cycles and turned into active-high byte enables for the data output stage. The memory array and the pad drivers belong to other blocks.

Top module: `burst_colgen`

## Requirements
- R1: While reset is asserted and after its release, with no command given, `burst_act`, `ap_req` and `byte_en` are all zero.
- R2: Burst length codes 0, 1, 2 and 3 give bursts of exactly 1, 2, 4 and 8 beats. `burst_act` is high for exactly that many consecutive cycles.
- R3: In linear ordering each beat's column is the previous column plus one, modulo 256, so 255 is followed by 0.
- R4: In wrap ordering (`wrap_mode`=1) the low log2(length) column bits count up modulo the length, and the upper bits keep the start column's value.
- R5: Length code 7 is a full-page burst. It counts linearly whatever `wrap_mode` says, passes from 255 to 0, and runs until it is stopped.
- R6: Commands are coded on `cmd` as 0 idle, 1 read, 2 write, 3 burst stop and 4 same-bank precharge. A burst opened without auto precharge ends after its current beat on a stop or a precharge. A read or write given during the burst starts a new burst from its own start column on the next beat.
- R7: A fixed-length burst opened with `auto_pre`=1 ignores stop, precharge, read and write commands until its last beat has been issued.
- R8: `ap_req` is high for exactly the one cycle that follows the last beat of a fixed-length auto-precharge burst. A full-page burst never raises it and can still be stopped.
- R9: Write beat 0 appears one cycle after the cycle in which the write is presented. Read beat 0 appears `cas_lat` cycles after the read is presented, for `cas_lat` from 1 to 3.
- R10: During a read beat, `byte_en` is the inverse of the `dqm` value presented two cycles earlier, so a mask bit of 1 disables that byte. Outside read beats `byte_en` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 3 | Command code (see R6) |
| start_col | input | 8 | First column of a new burst |
| auto_pre | input | 1 | Auto precharge when the burst ends |
| bl_code | input | 3 | Burst length code (see R2, R5) |
| wrap_mode | input | 1 | 1 selects wrap ordering |
| cas_lat | input | 2 | Read latency in cycles, 1 to 3 |
| dqm | input | 4 | Read byte masks, one per byte |
| col_addr | output | 8 | Column of the current beat |
| burst_act | output | 1 | A data beat is in this cycle |
| byte_en | output | 4 | Read byte enables, active high |
| ap_req | output | 1 | One-cycle auto-precharge request |

## Verification
The checker assumes that the write path and the delayed read path never both hold a beat in the same cycle. It therefore relies on the controller not starting a write while earlier read data is still in flight. The stimulus waits for every read to drain before any write, and it changes `cas_lat` only when the block is idle. Length codes 4 to 6 and `cas_lat` 0 are never driven. The bench model compares every cycle against burst lengths, orderings, stop and interrupt cases, the three latencies and walking mask patterns.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
   typedef enum logic [2:0] {
      CMD_IDLE  = 3'd0,
      CMD_READ  = 3'd1,
      CMD_WRITE = 3'd2,
      CMD_STOP  = 3'd3,
      CMD_PRECH = 3'd4
   } colgen_cmd_e;

   localparam logic [2:0] BLC_FULL = 3'b111;
endpackage

// File: rtl/colgen_seq.sv
module colgen_seq
   import colgen_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       cmd,
   input  logic [COL_W-1:0] start_col,
   input  logic             auto_pre,
   input  logic [2:0]       bl_code,
   input  logic             wrap_mode,
   output logic             g_act,
   output logic [COL_W-1:0] g_col,
   output logic             g_rd,
   output logic             g_wrap,
   output logic             g_last,
   output logic             g_ap_last,
   output logic             g_lock
);
   logic             act_q, rd_q, full_q, wrap_q, ap_q;
   logic [COL_W-1:0] col_q, cnt_q, mask_q;
   logic [COL_W-1:0] mask_d, col_nxt;
   logic             full_d, last, lock, is_rw, is_end, start, kill;

   always_comb begin
      case (bl_code)
         3'd1:    mask_d = COL_W'(1);
         3'd2:    mask_d = COL_W'(3);
         3'd3:    mask_d = COL_W'(7);
         default: mask_d = '0;
      endcase
      full_d = (bl_code == BLC_FULL);
   end

   assign last   = act_q && !full_q && (cnt_q == mask_q);
   assign lock   = act_q && ap_q && !last;
   assign is_rw  = (cmd == CMD_READ) || (cmd == CMD_WRITE);
   assign is_end = (cmd == CMD_STOP) || (cmd == CMD_PRECH);
   assign start  = is_rw && !lock;
   assign kill   = is_end && !lock && act_q;

   always_comb begin
      if (wrap_q) col_nxt = (col_q & ~mask_q) | ((col_q + COL_W'(1)) & mask_q);
      else        col_nxt = col_q + COL_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         rd_q   <= 1'b0;
         full_q <= 1'b0;
         wrap_q <= 1'b0;
         ap_q   <= 1'b0;
         col_q  <= '0;
         cnt_q  <= '0;
         mask_q <= '0;
      end else if (start) begin
         act_q  <= 1'b1;
         rd_q   <= (cmd == CMD_READ);
         full_q <= full_d;
         wrap_q <= wrap_mode && !full_d;
         ap_q   <= auto_pre && !full_d;
         col_q  <= start_col;
         cnt_q  <= '0;
         mask_q <= mask_d;
      end else if (kill || last) begin
         act_q  <= 1'b0;
      end else if (act_q) begin
         col_q  <= col_nxt;
         cnt_q  <= cnt_q + COL_W'(1);
      end
   end

   assign g_act     = act_q;
   assign g_col     = col_q;
   assign g_rd      = rd_q;
   assign g_wrap    = wrap_q;
   assign g_last    = last;
   assign g_ap_last = last && ap_q;
   assign g_lock    = lock;
endmodule

// File: rtl/colgen_lat_align.sv
module colgen_lat_align #(
   parameter int COL_W  = 8,
   parameter int MAX_CL = 3,
   parameter int CLW    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CLW-1:0]   cas_lat,
   input  logic             g_act,
   input  logic [COL_W-1:0] g_col,
   input  logic             g_rd,
   input  logic             g_ap_last,
   output logic             o_act,
   output logic [COL_W-1:0] o_col,
   output logic             o_rd,
   output logic             o_ap_last,
   output logic             wr_lane,
   output logic             rd_lane
);
   localparam int DEPTH = MAX_CL - 1;

   logic             d_act [DEPTH];
   logic [COL_W-1:0] d_col [DEPTH];
   logic             d_apl [DEPTH];
   logic             r_act, r_apl;
   logic [COL_W-1:0] r_col;

   for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_act[k] <= 1'b0;
            d_col[k] <= '0;
            d_apl[k] <= 1'b0;
         end else if (k == 0) begin
            d_act[k] <= g_act && g_rd;
            d_col[k] <= g_col;
            d_apl[k] <= g_ap_last;
         end else begin
            d_act[k] <= d_act[(k == 0) ? 0 : k-1];
            d_col[k] <= d_col[(k == 0) ? 0 : k-1];
            d_apl[k] <= d_apl[(k == 0) ? 0 : k-1];
         end
      end
   end

   always_comb begin
      r_act = g_act && g_rd;
      r_col = g_col;
      r_apl = g_ap_last;
      for (int k = 0; k < DEPTH; k++) begin
         if (cas_lat == CLW'(k + 2)) begin
            r_act = d_act[k];
            r_col = d_col[k];
            r_apl = d_apl[k];
         end
      end
   end

   assign wr_lane   = g_act && !g_rd;
   assign rd_lane   = r_act;
   assign o_act     = wr_lane || r_act;
   assign o_rd      = !wr_lane && r_act;
   assign o_col     = wr_lane ? g_col : r_col;
   assign o_ap_last = wr_lane ? g_ap_last : (r_act && r_apl);
endmodule

// File: rtl/colgen_dqm_pipe.sv
module colgen_dqm_pipe #(
   parameter int DQM_W   = 4,
   parameter int DQM_LAT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DQM_W-1:0] dqm,
   input  logic             rd_beat,
   output logic [DQM_W-1:0] byte_en
);
   logic [DQM_W-1:0] pipe [DQM_LAT];

   for (genvar k = 0; k < DQM_LAT; k++) begin : g_tap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pipe[k] <= '0;
         else if (k == 0) pipe[k] <= dqm;
         else             pipe[k] <= pipe[(k == 0) ? 0 : k-1];
      end
   end

   assign byte_en = rd_beat ? ~pipe[DQM_LAT-1] : '0;
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen #(
   parameter int COL_W   = 8,
   parameter int DQM_W   = 4,
   parameter int MAX_CL  = 3,
   parameter int DQM_LAT = 2,
   localparam int CLW    = $clog2(MAX_CL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       cmd,
   input  logic [COL_W-1:0] start_col,
   input  logic             auto_pre,
   input  logic [2:0]       bl_code,
   input  logic             wrap_mode,
   input  logic [CLW-1:0]   cas_lat,
   input  logic [DQM_W-1:0] dqm,
   output logic [COL_W-1:0] col_addr,
   output logic             burst_act,
   output logic [DQM_W-1:0] byte_en,
   output logic             ap_req
);
   if (COL_W < 4)   begin : g_bad_col  $error("COL_W must be at least 4");  end
   if (MAX_CL < 2)  begin : g_bad_cl   $error("MAX_CL must be at least 2"); end
   if (DQM_LAT < 1) begin : g_bad_dqm  $error("DQM_LAT must be at least 1"); end

   logic             g_act, g_rd, g_wrap, g_last, g_ap_last, g_lock;
   logic [COL_W-1:0] g_col;
   logic             o_act, o_rd, o_ap_last, wr_lane, rd_lane;
   logic             ap_q;

   colgen_seq #(.COL_W(COL_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .start_col(start_col),
      .auto_pre(auto_pre), .bl_code(bl_code), .wrap_mode(wrap_mode),
      .g_act(g_act), .g_col(g_col), .g_rd(g_rd), .g_wrap(g_wrap),
      .g_last(g_last), .g_ap_last(g_ap_last), .g_lock(g_lock)
   );

   colgen_lat_align #(.COL_W(COL_W), .MAX_CL(MAX_CL), .CLW(CLW)) i_align (
      .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat),
      .g_act(g_act), .g_col(g_col), .g_rd(g_rd), .g_ap_last(g_ap_last),
      .o_act(o_act), .o_col(col_addr), .o_rd(o_rd), .o_ap_last(o_ap_last),
      .wr_lane(wr_lane), .rd_lane(rd_lane)
   );

   colgen_dqm_pipe #(.DQM_W(DQM_W), .DQM_LAT(DQM_LAT)) i_dqm (
      .clk(clk), .rst_n(rst_n), .dqm(dqm), .rd_beat(o_rd), .byte_en(byte_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ap_q <= 1'b0;
      else        ap_q <= o_act && o_ap_last;
   end

   assign burst_act = o_act;
   assign ap_req    = ap_q;
endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
   parameter int COL_W = 8,
   parameter int DQM_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       cmd,
   input logic             g_act,
   input logic [COL_W-1:0] g_col,
   input logic             g_wrap,
   input logic             g_last,
   input logic             g_lock,
   input logic             wr_lane,
   input logic             rd_lane,
   input logic             burst_act,
   input logic [DQM_W-1:0] byte_en,
   input logic             ap_req
);
   AST_AP_BURST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      g_lock |=> g_act); // R7
   AST_WRAP_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (g_act && g_wrap && !g_last && cmd == 3'd0) |=>
      (g_col[COL_W-1:3] == $past(g_col[COL_W-1:3]))); // R4
   AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (g_act && !g_wrap && !g_last && cmd == 3'd0) |=>
      (g_col == $past(g_col) + COL_W'(1))); // R3
   AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_lane && rd_lane)); // R9
   AST_BE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !burst_act |-> (byte_en == '0)); // R10
   AST_AP_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      ap_req |-> $past(burst_act)); // R8
endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W), .DQM_W(DQM_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .cmd(cmd), .g_act(g_act), .g_col(g_col),
   .g_wrap(g_wrap), .g_last(g_last), .g_lock(g_lock), .wr_lane(wr_lane),
   .rd_lane(rd_lane), .burst_act(burst_act), .byte_en(byte_en), .ap_req(ap_req)
);

// File: tb/test_burst_colgen.sv
module test_burst_colgen;
   localparam int CLK_PERIOD = 10;
   localparam int HN = 8192;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cmd = 3'd0;
   logic [7:0] start_col = 8'd0;
   logic       auto_pre = 1'b0;
   logic [2:0] bl_code = 3'd0;
   logic       wrap_mode = 1'b0;
   logic [1:0] cas_lat = 2'd2;
   logic [3:0] dqm = 4'd0;
   logic [7:0] col_addr;
   logic       burst_act;
   logic [3:0] byte_en;
   logic       ap_req;

   int    checks = 0, fails = 0;
   string req = "R1";
   bit    dqm_walk = 1'b0;
   int    walk_n = 0;

   // behavioural model state
   bit m_act, m_rd, m_full, m_wrap, m_ap;
   int m_col, m_cnt, m_len;
   bit h_act [HN];
   int h_col [HN];
   bit h_rd  [HN];
   bit h_apl [HN];
   int dq_h  [HN];
   bit e_act [HN];
   int e_col [HN];
   bit e_apl [HN];
   bit e_rd  [HN];
   int cyc = 0;
   bit x_act = 0, x_ap = 0;
   int x_col = 0, x_be = 0;

   burst_colgen i_burst_colgen (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .start_col(start_col),
      .auto_pre(auto_pre), .bl_code(bl_code), .wrap_mode(wrap_mode),
      .cas_lat(cas_lat), .dqm(dqm), .col_addr(col_addr),
      .burst_act(burst_act), .byte_en(byte_en), .ap_req(ap_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (rst_n && cyc < HN - 2) begin
         bit last, lock;
         int idx;
         last = m_act && !m_full && (m_cnt == m_len - 1);
         lock = m_act && m_ap && !last;
         if (!lock && (cmd == 3'd1 || cmd == 3'd2)) begin
            m_act  = 1;
            m_rd   = (cmd == 3'd1);
            m_full = (bl_code == 3'd7);
            m_len  = (bl_code <= 3'd3) ? (1 << bl_code) : 1;
            m_wrap = wrap_mode && !m_full;
            m_ap   = auto_pre && !m_full;
            m_col  = start_col;
            m_cnt  = 0;
         end else if (!lock && m_act && (cmd == 3'd3 || cmd == 3'd4)) begin
            m_act = 0;
         end else if (m_act) begin
            if (last) m_act = 0;
            else begin
               if (m_wrap) m_col = (m_col / m_len) * m_len + ((m_col % m_len) + 1) % m_len;
               else        m_col = (m_col + 1) % 256;
               m_cnt++;
            end
         end
         cyc++;
         h_act[cyc] = m_act;
         h_col[cyc] = m_col;
         h_rd[cyc]  = m_rd;
         h_apl[cyc] = m_act && m_ap && !m_full && (m_cnt == m_len - 1);
         dq_h[cyc]  = dqm;
         if (m_act && !m_rd) begin
            e_act[cyc] = 1; e_col[cyc] = m_col; e_apl[cyc] = h_apl[cyc]; e_rd[cyc] = 0;
         end else begin
            idx = cyc - (int'(cas_lat) - 1);
            if (idx > 0 && h_act[idx] && h_rd[idx]) begin
               e_act[cyc] = 1; e_col[cyc] = h_col[idx]; e_apl[cyc] = h_apl[idx]; e_rd[cyc] = 1;
            end else begin
               e_act[cyc] = 0; e_col[cyc] = 0; e_apl[cyc] = 0; e_rd[cyc] = 0;
            end
         end
         x_act = e_act[cyc];
         x_col = e_col[cyc];
         x_ap  = e_act[cyc-1] && e_apl[cyc-1];
         x_be  = e_rd[cyc] ? (~dq_h[cyc-1] & 15) : 0;
      end
   end

   task automatic check(bit ok, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check(burst_act == x_act, "burst_act", int'(burst_act), int'(x_act));
         if (x_act) check(int'(col_addr) == x_col, "col_addr", int'(col_addr), x_col);
         check(ap_req == x_ap, "ap_req", int'(ap_req), int'(x_ap));
         check(int'(byte_en) == x_be, "byte_en", int'(byte_en), x_be);
      end
      if (dqm_walk) begin
         walk_n++;
         dqm = 4'((walk_n * 5 + 3) ^ (walk_n >> 2));
      end
   end

   task automatic issue(input logic [2:0] c, input int col, input bit ap,
                        input logic [2:0] bl, input bit wr);
      @(negedge clk);
      cmd = c; start_col = 8'(col); auto_pre = ap; bl_code = bl; wrap_mode = wr;
      @(negedge clk);
      cmd = 3'd0; auto_pre = 1'b0;
   endtask

   task automatic pulse(input logic [2:0] c);
      @(negedge clk);
      cmd = c;
      @(negedge clk);
      cmd = 3'd0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(burst_act == 0, "R1 burst_act in reset", int'(burst_act), 0);
      check(ap_req == 0, "R1 ap_req in reset", int'(ap_req), 0);
      check(byte_en == 0, "R1 byte_en in reset", int'(byte_en), 0);
      rst_n = 1'b1;
      idle(4);
      check(burst_act == 0 && byte_en == 0, "R1 idle after reset", int'(burst_act), 0);

      // R2: each fixed length, writes and reads
      req = "R2";
      for (int b = 0; b < 4; b++) begin
         issue(3'd2, 16 + b * 32, 0, 3'(b), 0);
         idle(10);
         issue(3'd1, 40 + b, 0, 3'(b), 0);
         idle(10);
      end

      // R3: linear crossing of the page end
      req = "R3";
      issue(3'd1, 252, 0, 3'd3, 0);
      idle(12);
      issue(3'd2, 254, 0, 3'd2, 0);
      idle(8);

      // R4: wrap ordering
      req = "R4";
      issue(3'd2, 8'h1D, 0, 3'd3, 1);
      idle(10);
      issue(3'd1, 8'hFE, 0, 3'd2, 1);
      idle(8);
      issue(3'd2, 8'h43, 0, 3'd1, 1);
      idle(6);

      // R5: full page, stopped after passing 255, wrap bit ignored
      req = "R5";
      issue(3'd2, 250, 0, 3'd7, 0);
      idle(10);
      pulse(3'd3);
      idle(6);
      issue(3'd1, 253, 0, 3'd7, 1);
      idle(7);
      pulse(3'd3);
      idle(8);

      // R6: stop, precharge and interruption of plain bursts
      req = "R6";
      issue(3'd1, 96, 0, 3'd3, 0);
      idle(2);
      pulse(3'd3);
      idle(8);
      issue(3'd2, 120, 0, 3'd3, 0);
      idle(1);
      pulse(3'd4);
      idle(6);
      issue(3'd2, 130, 0, 3'd3, 0);
      idle(1);
      issue(3'd2, 200, 0, 3'd2, 0);
      idle(8);
      issue(3'd1, 60, 0, 3'd3, 1);
      idle(1);
      issue(3'd1, 70, 0, 3'd1, 0);
      idle(8);

      // R7: auto-precharge bursts cannot be cut short
      req = "R7";
      issue(3'd2, 8, 1, 3'd3, 0);
      pulse(3'd3);
      pulse(3'd4);
      issue(3'd2, 100, 0, 3'd1, 0);
      idle(10);
      issue(3'd1, 33, 1, 3'd2, 1);
      pulse(3'd1);
      idle(10);

      // R8: request pulse, none for full page
      req = "R8";
      issue(3'd1, 5, 1, 3'd0, 0);
      idle(6);
      issue(3'd2, 77, 1, 3'd1, 0);
      idle(6);
      issue(3'd2, 180, 1, 3'd7, 0);
      idle(4);
      pulse(3'd3);
      idle(6);

      // R9: read latency 1, 2 and 3
      req = "R9";
      for (int c = 1; c <= 3; c++) begin
         cas_lat = 2'(c);
         issue(3'd1, 10 * c, 0, 3'd2, 0);
         idle(8);
         issue(3'd2, 10 * c + 5, 1, 3'd1, 0);
         idle(6);
      end

      // R10: byte enables from walking masks
      req = "R10";
      dqm_walk = 1'b1;
      for (int c = 1; c <= 3; c++) begin
         cas_lat = 2'(c);
         issue(3'd1, 64, 0, 3'd3, 0);
         idle(10);
         issue(3'd1, 220, 0, 3'd7, 0);
         idle(12);
         pulse(3'd3);
         idle(8);
      end
      dqm_walk = 1'b0;
      idle(4);

      summary();
      $finish;
   end
endmodule